// File: doc/BRIEF.md
# Banked System Control Register File

This block is the system-control register file that a CPU core reaches with its move-to-coprocessor and move-from-coprocessor transfers. Each request carries a four-part selector (opcode1, CRn, CRm, opcode2), a direction, write data, and the core's current privilege level and security world. Three architectural registers live here: a control word whose bit 0 turns address translation on, a first-level translation table base, and a word of sixteen two-bit domain permissions. The table base and the domain word each hold one copy per security world. The control word has a single copy.

A request is accepted in the cycle it is presented. One cycle later the block returns a response strobe, the read data, and an undefined-instruction flag. Any write lands on that same clock edge. The block raises the flag when the selector names no register, when the core is in user mode, or when the secure world writes a banked register while the secure-write-disable input is high. A refused request changes nothing. The control word's enable bit and the current world's table base and domain word are driven out continuously for the translation logic.

The response path is a four-state machine. IDLE means no response this cycle. RD_DONE returns read data. WR_DONE acknowledges a write. TRAP flags an undefined instruction with zero data. The next state depends only on the request presented in the current cycle. With no request the next state is IDLE. A refused request leads to TRAP. An accepted write leads to WR_DONE and an accepted read leads to RD_DONE. Any state can move to any state, so requests can run back to back.

Top module: `sysreg_bank`

## Requirements
- R1: A selector with opcode1=0, CRm=0 and opcode2=0 picks a register by CRn: 1 is the control word, 2 is the table base, 3 is the domain word.
- R2: The table base and the domain word keep two copies. A privileged request with cur_secure=1 uses the secure copy and one with cur_secure=0 uses the non-secure copy. Writing one copy leaves the other unchanged.
- R3: Any request made with cur_priv=0 is answered with rsp_undef=1 and rsp_rdata=0, and it changes no register.
- R4: A write to the table base or the domain word with cur_priv=1, cur_secure=1 and sec_wr_disable=1 is answered with rsp_undef=1 and leaves the register unchanged. sec_wr_disable has no effect on non-secure writes or on writes to the control word.
- R5: A table base write stores bits [31:7] (the table address), [4:3] (outer walk cacheability), [1] (shared) and [0] (inner cacheable). Bits [6:5] and [2] always read as 0. A read returns the stored value.
- R6: After reset every register in both worlds reads 0, and mmu_enable, tbl_base and domain_acc are 0.
- R7: A read of the control word returns exactly the 32 bits last written, so a read-modify-write keeps every other bit. Bit 0 of the control word drives mmu_enable.
- R8: A selector that picks no register (including a nonzero opcode1) is answered with rsp_undef=1. Its read data is 0, and a write to it changes no register.
- R9: Each request cycle gives rsp_valid=1 in the next cycle, and a cycle with no request gives rsp_valid=0 in the next cycle. A write is visible to a request in the next cycle and on the exported outputs.
- R10: tbl_base and domain_acc show the copy of the world given by cur_secure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Register transfer request this cycle |
| req_write | input | 1 | 1 = move to register, 0 = move from register |
| req_op1 | input | 3 | Opcode1 of the selector |
| req_crn | input | 4 | Primary register number |
| req_crm | input | 4 | Secondary register number |
| req_op2 | input | 3 | Opcode2 of the selector |
| req_wdata | input | 32 | Write data |
| cur_priv | input | 1 | 1 = privileged mode |
| cur_secure | input | 1 | 1 = secure world |
| sec_wr_disable | input | 1 | Blocks secure writes to banked registers |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | 32 | Read data, 0 for writes and refused requests |
| rsp_undef | output | 1 | Undefined-instruction indication |
| mmu_enable | output | 1 | Control word bit 0 |
| tbl_base | output | 32 | Current world's table base |
| domain_acc | output | 32 | Current world's domain permissions |

## Verification
The bench issues a request in every cycle, so one request's register commit and the next request's decode share a clock edge. It provokes this by writing a register and reading it straight after, in the same world and in the other world. It then compares the read data and the exported words against a model that applies the write before the following request. The second collision is between two refusal causes, user mode and the secure-write-disable input. The bench raises both together and judges that exactly one trap is reported and that no copy in either world moves.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

    localparam int DATA_W  = 32;
    localparam int WORLDS  = 2;
    localparam int WORLD_W = $clog2(WORLDS);

    localparam logic [3:0] CRN_CTRL = 4'd1;
    localparam logic [3:0] CRN_TTB  = 4'd2;
    localparam logic [3:0] CRN_DAC  = 4'd3;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_TTB,
        SEL_DAC
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_DONE,
        ST_WR_DONE,
        ST_TRAP
    } rsp_st_e;

endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
    import sysreg_pkg::*;
(
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    input  logic       write,
    input  logic       priv,
    input  logic       secure,
    input  logic       sec_dis,
    output sel_e       sel,
    output logic       trap
);

    logic base_tuple;
    logic banked;
    logic sec_block;

    assign base_tuple = (op1 == 3'd0) && (crm == 4'd0) && (op2 == 3'd0);

    always_comb begin
        sel = SEL_NONE;
        if (base_tuple) begin
            unique case (crn)
                CRN_CTRL: sel = SEL_CTRL;
                CRN_TTB:  sel = SEL_TTB;
                CRN_DAC:  sel = SEL_DAC;
                default:  sel = SEL_NONE;
            endcase
        end
    end

    assign banked    = (sel == SEL_TTB) || (sel == SEL_DAC);
    assign sec_block = write && secure && sec_dis && banked;
    assign trap      = (sel == SEL_NONE) || !priv || sec_block;

endmodule

// File: rtl/sysreg_store.sv
module sysreg_store
    import sysreg_pkg::*;
#(
    parameter logic [DATA_W-1:0] TTB_MASK = 32'hFFFF_FF9B,
    parameter logic [DATA_W-1:0] CTRL_RST = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  sel_e               sel,
    input  logic [WORLD_W-1:0] world,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    output logic [DATA_W-1:0]  ctrl_q,
    output logic [DATA_W-1:0]  ttb_cur,
    output logic [DATA_W-1:0]  dac_cur
);

    logic [DATA_W-1:0] ttb_arr [WORLDS];
    logic [DATA_W-1:0] dac_arr [WORLDS];
    logic [DATA_W-1:0] ctrl_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_r <= CTRL_RST;
        else if (wr_en && sel == SEL_CTRL)
            ctrl_r <= wr_data;
    end

    for (genvar w = 0; w < WORLDS; w++) begin : g_world
        logic [DATA_W-1:0] ttb_q;
        logic [DATA_W-1:0] dac_q;
        logic              hit;

        assign hit = wr_en && (world == WORLD_W'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ttb_q <= '0;
                dac_q <= '0;
            end else if (hit) begin
                if (sel == SEL_TTB) ttb_q <= wr_data & TTB_MASK;
                if (sel == SEL_DAC) dac_q <= wr_data;
            end
        end

        assign ttb_arr[w] = ttb_q;
        assign dac_arr[w] = dac_q;
    end

    assign ctrl_q  = ctrl_r;
    assign ttb_cur = ttb_arr[world];
    assign dac_cur = dac_arr[world];

    always_comb begin
        unique case (sel)
            SEL_CTRL: rd_data = ctrl_r;
            SEL_TTB:  rd_data = ttb_arr[world];
            SEL_DAC:  rd_data = dac_arr[world];
            default:  rd_data = '0;
        endcase
    end

    // R2: a write in one world never disturbs the other world's copies
    a_r2_secure_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && world == WORLD_W'(0)) |=> ($stable(ttb_arr[1]) && $stable(dac_arr[1])));
    a_r2_nonsec_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && world == WORLD_W'(1)) |=> ($stable(ttb_arr[0]) && $stable(dac_arr[0])));

    // R5: unstored table base bits stay clear in both copies
    a_r5_ttb_holes: assert property (@(posedge clk) disable iff (!rst_n)
        ((ttb_arr[0] & ~TTB_MASK) == '0) && ((ttb_arr[1] & ~TTB_MASK) == '0));

endmodule

// File: rtl/sysreg_rsp_fsm.sv
module sysreg_rsp_fsm
    import sysreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              trap,
    input  logic [DATA_W-1:0] rd_value,
    output logic              rsp_valid,
    output logic              rsp_undef,
    output logic [DATA_W-1:0] rsp_rdata
);

    rsp_st_e           state, state_nx;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        if (!req_valid)     state_nx = ST_IDLE;
        else if (trap)      state_nx = ST_TRAP;
        else if (req_write) state_nx = ST_WR_DONE;
        else                state_nx = ST_RD_DONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state   <= state_nx;
            rdata_q <= (state_nx == ST_RD_DONE) ? rd_value : '0;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_undef = 1'b0;
        rsp_rdata = '0;
        unique case (state)
            ST_IDLE:    ;
            ST_RD_DONE: begin
                rsp_valid = 1'b1;
                rsp_rdata = rdata_q;
            end
            ST_WR_DONE: rsp_valid = 1'b1;
            ST_TRAP: begin
                rsp_valid = 1'b1;
                rsp_undef = 1'b1;
            end
            default:    ;
        endcase
    end

    // R9: one response per request, none without
    a_r9_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R8: a trapped response carries no data
    a_r8_trap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_undef |-> (rsp_rdata == '0));

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
    import sysreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [2:0]  req_op1,
    input  logic [3:0]  req_crn,
    input  logic [3:0]  req_crm,
    input  logic [2:0]  req_op2,
    input  logic [31:0] req_wdata,
    input  logic        cur_priv,
    input  logic        cur_secure,
    input  logic        sec_wr_disable,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        rsp_undef,
    output logic        mmu_enable,
    output logic [31:0] tbl_base,
    output logic [31:0] domain_acc
);

    sel_e              sel;
    logic              trap;
    logic              wr_en;
    logic [DATA_W-1:0] rd_value;
    logic [DATA_W-1:0] ctrl_q;
    logic [WORLD_W-1:0] world;

    assign world = WORLD_W'(cur_secure);

    sysreg_decode u_decode (
        .op1     (req_op1),
        .crn     (req_crn),
        .crm     (req_crm),
        .op2     (req_op2),
        .write   (req_write),
        .priv    (cur_priv),
        .secure  (cur_secure),
        .sec_dis (sec_wr_disable),
        .sel     (sel),
        .trap    (trap)
    );

    assign wr_en = req_valid && req_write && !trap;

    sysreg_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .sel     (sel),
        .world   (world),
        .wr_data (req_wdata),
        .rd_data (rd_value),
        .ctrl_q  (ctrl_q),
        .ttb_cur (tbl_base),
        .dac_cur (domain_acc)
    );

    sysreg_rsp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .trap      (trap),
        .rd_value  (rd_value),
        .rsp_valid (rsp_valid),
        .rsp_undef (rsp_undef),
        .rsp_rdata (rsp_rdata)
    );

    assign mmu_enable = ctrl_q[0];

    // R3: user-mode requests always trap and leave the control word alone
    a_r3_user_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cur_priv) |=> rsp_undef);
    a_r3_user_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cur_priv) |=> $stable(mmu_enable));
    // R4: secure writes to banked registers are refused under the disable input
    a_r4_sec_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && cur_priv && cur_secure && sec_wr_disable &&
         req_op1 == 3'd0 && req_crm == 4'd0 && req_op2 == 3'd0 &&
         (req_crn == CRN_TTB || req_crn == CRN_DAC)) |=> rsp_undef);
    // R1: a privileged read of a defined selector never traps
    a_r1_hit_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && cur_priv && req_op1 == 3'd0 && req_crm == 4'd0 &&
         req_op2 == 3'd0 && (req_crn == CRN_CTRL || req_crn == CRN_TTB || req_crn == CRN_DAC))
        |=> (rsp_valid && !rsp_undef));

endmodule

// File: tb/test_sysreg_bank.sv
module test_sysreg_bank;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] TTB_MASK = 32'hFFFF_FF9B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_op1 = '0;
    logic [3:0]  req_crn = '0;
    logic [3:0]  req_crm = '0;
    logic [2:0]  req_op2 = '0;
    logic [31:0] req_wdata = '0;
    logic        cur_priv = 1'b0;
    logic        cur_secure = 1'b0;
    logic        sec_wr_disable = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_undef;
    logic        mmu_enable;
    logic [31:0] tbl_base;
    logic [31:0] domain_acc;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [31:0] m_ctrl;
    logic [31:0] m_ttb [2];
    logic [31:0] m_dac [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    sysreg_bank i_sysreg_bank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm), .req_op2(req_op2),
        .req_wdata(req_wdata), .cur_priv(cur_priv), .cur_secure(cur_secure),
        .sec_wr_disable(sec_wr_disable), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_undef(rsp_undef), .mmu_enable(mmu_enable), .tbl_base(tbl_base),
        .domain_acc(domain_acc)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        check(mmu_enable == m_ctrl[0], {tag, " R7 mmu_enable"}, 32'(mmu_enable), 32'(m_ctrl[0]));
        check(tbl_base == m_ttb[cur_secure], {tag, " R10 tbl_base"}, tbl_base, m_ttb[cur_secure]);
        check(domain_acc == m_dac[cur_secure], {tag, " R10 domain_acc"}, domain_acc,
              m_dac[cur_secure]);
    endtask

    // one request per cycle; expected response computed from the requirements
    task automatic access(input bit wr, input logic [2:0] o1, input logic [3:0] n,
                          input logic [3:0] m, input logic [2:0] o2, input logic [31:0] wd,
                          input bit pv, input bit sc, input bit ds, input string tag);
        bit          hit;
        bit          undef;
        logic [31:0] cur;
        logic [31:0] exp_rd;
        hit   = (o1 == 0) && (m == 0) && (o2 == 0) && (n >= 1) && (n <= 3);
        undef = !hit || !pv || (wr && sc && ds && (n == 2 || n == 3));
        cur   = (n == 1) ? m_ctrl : (n == 2) ? m_ttb[sc] : m_dac[sc];
        exp_rd = (!wr && !undef) ? cur : 32'h0;
        req_valid = 1'b1; req_write = wr; req_op1 = o1; req_crn = n; req_crm = m;
        req_op2 = o2; req_wdata = wd; cur_priv = pv; cur_secure = sc; sec_wr_disable = ds;
        @(negedge clk);
        if (wr && !undef) begin
            if (n == 1) m_ctrl = wd;
            else if (n == 2) m_ttb[sc] = wd & TTB_MASK;
            else m_dac[sc] = wd;
        end
        check(rsp_valid == 1'b1, {tag, " R9 rsp_valid"}, 32'(rsp_valid), 32'd1);
        check(rsp_undef == undef, {tag, " R8 rsp_undef"}, 32'(rsp_undef), 32'(undef));
        check(rsp_rdata == exp_rd, {tag, " R1 rsp_rdata"}, rsp_rdata, exp_rd);
        check_outputs(tag);
    endtask

    task automatic rd(input logic [3:0] n, input bit sc, input string tag);
        access(1'b0, 3'd0, n, 4'd0, 3'd0, 32'h0, 1'b1, sc, 1'b0, tag);
    endtask

    task automatic wrr(input logic [3:0] n, input logic [31:0] d, input bit sc,
                       input bit ds, input string tag);
        access(1'b1, 3'd0, n, 4'd0, 3'd0, d, 1'b1, sc, ds, tag);
    endtask

    task automatic idle(input string tag);
        req_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0, {tag, " R9 idle rsp_valid"}, 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        m_ctrl = '0;
        for (int w = 0; w < 2; w++) begin m_ttb[w] = '0; m_dac[w] = '0; end
        @(negedge clk);
        @(negedge clk);
        // R6: reset state
        check(rsp_valid == 1'b0, "R6 reset rsp_valid", 32'(rsp_valid), 32'd0);
        check_outputs("R6 reset");
        rst_n = 1'b1;
        idle("R6 post-reset");
        for (int s = 0; s < 2; s++)
            for (int n = 1; n <= 3; n++) rd(4'(n), s[0], "R6 reset read");

        // R1 R8: exhaustive read sweep over every selector, non-secure privileged
        for (int a = 0; a < 8; a++)
            for (int n = 0; n < 16; n++)
                for (int m = 0; m < 16; m++)
                    for (int b = 0; b < 8; b++)
                        access(1'b0, 3'(a), 4'(n), 4'(m), 3'(b), 32'h0, 1'b1, 1'b0,
                               1'b0, "R1 read sweep");

        // R2 R10: banked copies, write then read back immediately in both worlds
        wrr(4'd2, 32'h1234_5679, 1'b0, 1'b0, "R2 ns ttb");
        wrr(4'd2, 32'hA5A5_A5A5, 1'b1, 1'b0, "R2 s ttb");
        rd(4'd2, 1'b0, "R2 ns ttb readback");
        rd(4'd2, 1'b1, "R2 s ttb readback");
        wrr(4'd3, 32'h0000_FFFF, 1'b0, 1'b0, "R2 ns dac");
        rd(4'd3, 1'b1, "R2 s dac untouched");
        wrr(4'd3, 32'h5555_0001, 1'b1, 1'b0, "R2 s dac");
        rd(4'd3, 1'b0, "R2 ns dac readback");
        rd(4'd3, 1'b1, "R2 s dac readback");

        // R5: table base field masking
        wrr(4'd2, 32'hFFFF_FFFF, 1'b0, 1'b0, "R5 all ones");
        rd(4'd2, 1'b0, "R5 all ones readback");
        wrr(4'd2, 32'h0000_007F, 1'b1, 1'b0, "R5 low bits");
        rd(4'd2, 1'b1, "R5 low bits readback");
        for (int k = 0; k < 32; k++) begin
            wrr(4'd2, 32'h1 << k, k[0], 1'b0, "R5 walking one");
            rd(4'd2, k[0], "R5 walking one readback");
        end

        // R7: read-modify-write of the control word
        wrr(4'd1, 32'hC0DE_5A50, 1'b0, 1'b0, "R7 ctrl seed");
        rd(4'd1, 1'b1, "R7 ctrl read");
        wrr(4'd1, m_ctrl | 32'h1, 1'b1, 1'b0, "R7 ctrl set enable");
        rd(4'd1, 1'b0, "R7 ctrl exact");
        wrr(4'd1, m_ctrl & ~32'h1, 1'b0, 1'b0, "R7 ctrl clear enable");

        // R3: user mode, every register, both directions, both worlds
        for (int s = 0; s < 2; s++)
            for (int n = 1; n <= 3; n++) begin
                access(1'b1, 3'd0, 4'(n), 4'd0, 3'd0, 32'hDEAD_BEEF, 1'b0, s[0], 1'b0,
                       "R3 user write");
                access(1'b0, 3'd0, 4'(n), 4'd0, 3'd0, 32'h0, 1'b0, s[0], 1'b0,
                       "R3 user read");
                rd(4'(n), s[0], "R3 unchanged");
            end

        // R4: secure write disable
        wrr(4'd2, 32'h7777_7777, 1'b1, 1'b1, "R4 s ttb blocked");
        wrr(4'd3, 32'h7777_7777, 1'b1, 1'b1, "R4 s dac blocked");
        rd(4'd2, 1'b1, "R4 s ttb unchanged");
        rd(4'd3, 1'b1, "R4 s dac unchanged");
        wrr(4'd2, 32'h3333_3380, 1'b0, 1'b1, "R4 ns ttb allowed");
        wrr(4'd3, 32'h3333_3333, 1'b0, 1'b1, "R4 ns dac allowed");
        wrr(4'd1, 32'h0000_0001, 1'b1, 1'b1, "R4 s ctrl allowed");
        rd(4'd1, 1'b1, "R4 ctrl readback");
        // R3 and R4 causes together
        access(1'b1, 3'd0, 4'd2, 4'd0, 3'd0, 32'h1111_1111, 1'b0, 1'b1, 1'b1,
               "R4 user plus disable");
        rd(4'd2, 1'b1, "R4 s ttb still unchanged");
        rd(4'd2, 1'b0, "R4 ns ttb still unchanged");

        // R8: writes to every undefined selector change nothing
        for (int a = 0; a < 8; a++)
            for (int n = 0; n < 16; n++)
                for (int m = 0; m < 16; m++)
                    for (int b = 0; b < 8; b++)
                        if (!(a == 0 && m == 0 && b == 0 && n >= 1 && n <= 3))
                            access(1'b1, 3'(a), 4'(n), 4'(m), 3'(b), {4'(n), 4'(m), 24'hF0F0F1},
                                   1'b1, m[0], 1'b0, "R8 write sweep");
        for (int s = 0; s < 2; s++)
            for (int n = 1; n <= 3; n++) rd(4'(n), s[0], "R8 state intact");

        // R9: idle gap then back-to-back traffic
        idle("R9 gap");
        idle("R9 gap2");
        wrr(4'd3, 32'h0F0F_0F0F, 1'b0, 1'b0, "R9 b2b write");
        rd(4'd3, 1'b0, "R9 b2b read");
        idle("R9 end");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule